// File: doc/BRIEF.md
# Gated Frequency Tracker With Hold

This block measures the frequency of an external oscillator and turns that measurement into a tuning word for a numerically controlled synthesizer. It keeps the synthesizer locked to the oscillator. The oscillator is brought in as a raw digital input. The block counts its rising edges over a gate window of fixed length. It then scales each count by a fixed constant and by a correction factor supplied from outside. When it is allowed to, it publishes the result as a word and raises a one-cycle strobe.

A sense input tells the block whether the external oscillator is powered.
- When the sense input is high, the block is in track mode and publishes a new word after every window.
- When the sense input is low, the block is in hold mode and the last published word stays on the output, so the synthesizer can stand in for the oscillator.
- A lock input suppresses publishing regardless of the sense input. This keeps a stored frequency that can be recalled later.

The sense input is filtered so that short glitches on it cannot flip the mode.

Control is a four-state machine:
- **GATE** waits for the window to close. The transition *window_done* moves it to SCALE_A.
- **SCALE_A** forms the count times the fixed constant. The transition *always* moves it to SCALE_B.
- **SCALE_B** multiplies by the correction. The transition *always* moves it to PUBLISH.
- **PUBLISH** updates the word and raises the strobe only if the accepted mode is track and lock is low. The transition *always* returns it to GATE.

Top module: `gated_freq_tracker`

## Requirements
- R1: After reset, `word_o` is 0, `word_stb_o` is 0 and `track_o` is 0 (hold).
- R2: The count of a window equals the number of rising edges of `ref_in` seen in exactly `GATE_CYCLES` consecutive clock cycles, for any input period of at least 3 clock cycles. The count register is sized from `GATE_CYCLES`, so it never wraps. With the default of 5,000,000 cycles it holds more than 600,000 counts.
- R3: The published word is bits [SCALE_SHIFT+30 +: 32] of count × SCALE_NUM × `corr_in`. Here `corr_in` is unsigned with 30 fraction bits, so 0x4000_0000 means 1.0. The default constants are SCALE_NUM = 360287970 and SCALE_SHIFT = 20, which approximate count × 10 × 2^32 / 125e6.
- R4: In track mode with lock low, `word_stb_o` is high for one cycle per window. Successive strobes are `GATE_CYCLES` cycles apart, and `word_o` takes the new value in the same cycle as the strobe.
- R5: While the accepted mode is hold, no strobe is issued and `word_o` keeps the word from the most recent track-mode window.
- R6: While `lock_in` is high, no strobe is issued and `word_o` is unchanged, even in track mode.
- R7: `sense_in` passes through a two-flop synchronizer. A new level is accepted, and shown on `track_o`, only after it has persisted for `HOLD_CYCLES` consecutive synchronized cycles. The accepted level changes exactly `HOLD_CYCLES`+2 clock edges after the input changes. A pulse shorter than `HOLD_CYCLES` cycles has no effect.
- R8: No strobe appears before the first full window. The first strobe comes `GATE_CYCLES`+4 clock edges after reset is released.
- R9: After hold or lock ends, the next published word reflects the input frequency at that time.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ref_in | input | 1 | Raw oscillator input whose edges are counted |
| sense_in | input | 1 | High selects track mode, low selects hold mode (asynchronous) |
| lock_in | input | 1 | High suppresses all word updates (synchronous) |
| corr_in | input | CORR_W | Correction factor, unsigned with 30 fraction bits |
| word_o | output | WORD_W | Published tuning word |
| word_stb_o | output | 1 | One-cycle pulse when `word_o` is updated |
| track_o | output | 1 | Accepted mode, high for track |

## Verification
The sequence from a window's close to its published word is fixed: the closing pulse follows the last counting edge, and three more edges pass through SCALE_A, SCALE_B and PUBLISH. So the first strobe is due at edge `GATE_CYCLES`+4 and every later strobe exactly `GATE_CYCLES` edges after the one before. The bench samples on falling edges and compares strobe times against these numbers. After each change of frequency or correction it discards the first strobe, because that window is mixed, and checks the second, which covers a pure window. Mode filtering is checked one edge before and one edge after edge `HOLD_CYCLES`+2.

// File: rtl/ftrk_pkg.sv
package ftrk_pkg;

    // Control sequence from window close to publication
    typedef enum logic [1:0] {
        ST_GATE    = 2'd0,
        ST_SCALE_A = 2'd1,
        ST_SCALE_B = 2'd2,
        ST_PUBLISH = 2'd3
    } trk_state_t;

    // Fraction bits of the correction factor
    localparam int CORR_FRAC = 30;

endpackage

// File: rtl/ftrk_edge_sync.sv
module ftrk_edge_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic async_i,
    output logic rise_o
);

    logic [STAGES-1:0] chain_q;
    logic              prev_q;

    generate
        if (STAGES == 1) begin : g_single
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) chain_q <= '0;
                else        chain_q <= async_i;
            end
        end else begin : g_multi
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) chain_q <= '0;
                else        chain_q <= {chain_q[STAGES-2:0], async_i};
            end
        end
    endgenerate

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) prev_q <= 1'b0;
        else        prev_q <= chain_q[STAGES-1];
    end

    assign rise_o = chain_q[STAGES-1] & ~prev_q;

endmodule

// File: rtl/ftrk_sense_filter.sv
module ftrk_sense_filter #(
    parameter int HOLD_CYCLES = 200000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic raw_i,
    output logic level_o
);

    localparam int HW = (HOLD_CYCLES > 2) ? $clog2(HOLD_CYCLES) : 1;

    logic [1:0]    sync_q;
    logic [HW-1:0] run_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sync_q <= 2'b00;
        else        sync_q <= {sync_q[0], raw_i};
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            run_q   <= '0;
            level_o <= 1'b0;
        end else if (sync_q[1] == level_o) begin
            run_q <= '0;
        end else if (run_q == HW'(HOLD_CYCLES - 1)) begin
            run_q   <= '0;
            level_o <= sync_q[1];
        end else begin
            run_q <= run_q + HW'(1);
        end
    end

endmodule

// File: rtl/ftrk_gate_counter.sv
module ftrk_gate_counter #(
    parameter int GATE_CYCLES = 5000000,
    parameter int CNT_W       = 23
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             rise_i,
    output logic             done_o,
    output logic [CNT_W-1:0] count_o
);

    localparam int TW = $clog2(GATE_CYCLES);

    logic [TW-1:0]    tmr_q;
    logic [CNT_W-1:0] acc_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            tmr_q   <= '0;
            acc_q   <= '0;
            count_o <= '0;
            done_o  <= 1'b0;
        end else begin
            done_o <= 1'b0;
            if (tmr_q == TW'(GATE_CYCLES - 1)) begin
                tmr_q   <= '0;
                acc_q   <= '0;
                count_o <= acc_q + CNT_W'(rise_i);
                done_o  <= 1'b1;
            end else begin
                tmr_q <= tmr_q + TW'(1);
                acc_q <= acc_q + CNT_W'(rise_i);
            end
        end
    end

endmodule

// File: rtl/ftrk_scaler.sv
module ftrk_scaler #(
    parameter int              CNT_W     = 23,
    parameter int              CORR_W    = 32,
    parameter int              WORD_W    = 32,
    parameter longint unsigned SCALE_NUM = 64'd360287970,
    parameter int              SCALE_W   = 29,
    parameter int              SHIFT     = 50
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load_a_i,
    input  logic              load_b_i,
    input  logic [CNT_W-1:0]  count_i,
    input  logic [CORR_W-1:0] corr_i,
    output logic [WORD_W-1:0] word_o
);

    localparam int PA_W  = CNT_W + SCALE_W;
    localparam int RAW_B = PA_W + CORR_W;
    localparam int NEED  = SHIFT + WORD_W;
    localparam int PB_W  = (RAW_B > NEED) ? RAW_B : NEED;
    localparam logic [SCALE_W-1:0] K = SCALE_W'(SCALE_NUM);

    logic [PA_W-1:0] prod_a_q;
    logic [PB_W-1:0] prod_b_q;
    logic            unused_scaler;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            prod_a_q <= '0;
            prod_b_q <= '0;
        end else begin
            if (load_a_i) prod_a_q <= PA_W'(count_i) * PA_W'(K);
            if (load_b_i) prod_b_q <= PB_W'(prod_a_q) * PB_W'(corr_i);
        end
    end

    assign word_o        = prod_b_q[SHIFT +: WORD_W];
    assign unused_scaler = ^prod_b_q;

endmodule

// File: rtl/gated_freq_tracker.sv
module gated_freq_tracker #(
    parameter int              GATE_CYCLES = 5000000,
    parameter int              HOLD_CYCLES = 200000,
    parameter int              SYNC_STAGES = 2,
    parameter int              CORR_W      = 32,
    parameter int              WORD_W      = 32,
    parameter longint unsigned SCALE_NUM   = 64'd360287970,
    parameter int              SCALE_W     = 29,
    parameter int              SCALE_SHIFT = 20
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ref_in,
    input  logic              sense_in,
    input  logic              lock_in,
    input  logic [CORR_W-1:0] corr_in,
    output logic [WORD_W-1:0] word_o,
    output logic              word_stb_o,
    output logic              track_o
);

    import ftrk_pkg::*;

    localparam int CNT_W = $clog2(GATE_CYCLES + 1);
    localparam int SHIFT = SCALE_SHIFT + CORR_FRAC;

    trk_state_t        state_q, state_d;
    logic              ref_rise;
    logic              win_done;
    logic [CNT_W-1:0]  win_count;
    logic [WORD_W-1:0] scaled;
    logic              publish_ok;

    ftrk_edge_sync #(.STAGES(SYNC_STAGES)) u_ref_sync (
        .clk     (clk),
        .rst_n   (rst_n),
        .async_i (ref_in),
        .rise_o  (ref_rise)
    );

    ftrk_sense_filter #(.HOLD_CYCLES(HOLD_CYCLES)) u_sense (
        .clk     (clk),
        .rst_n   (rst_n),
        .raw_i   (sense_in),
        .level_o (track_o)
    );

    ftrk_gate_counter #(.GATE_CYCLES(GATE_CYCLES), .CNT_W(CNT_W)) u_gate (
        .clk     (clk),
        .rst_n   (rst_n),
        .rise_i  (ref_rise),
        .done_o  (win_done),
        .count_o (win_count)
    );

    ftrk_scaler #(
        .CNT_W     (CNT_W),
        .CORR_W    (CORR_W),
        .WORD_W    (WORD_W),
        .SCALE_NUM (SCALE_NUM),
        .SCALE_W   (SCALE_W),
        .SHIFT     (SHIFT)
    ) u_scale (
        .clk      (clk),
        .rst_n    (rst_n),
        .load_a_i (state_q == ST_SCALE_A),
        .load_b_i (state_q == ST_SCALE_B),
        .count_i  (win_count),
        .corr_i   (corr_in),
        .word_o   (scaled)
    );

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_GATE;
        else        state_q <= state_d;
    end

    // Next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_GATE:    if (win_done) state_d = ST_SCALE_A;
            ST_SCALE_A: state_d = ST_SCALE_B;
            ST_SCALE_B: state_d = ST_PUBLISH;
            ST_PUBLISH: state_d = ST_GATE;
            default:    state_d = ST_GATE;
        endcase
    end

    assign publish_ok = track_o && !lock_in;

    // Output process
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            word_o     <= '0;
            word_stb_o <= 1'b0;
        end else begin
            word_stb_o <= (state_q == ST_PUBLISH) && publish_ok;
            if ((state_q == ST_PUBLISH) && publish_ok) word_o <= scaled;
        end
    end

endmodule

// File: rtl/ftrk_checker.sv
module ftrk_checker #(
    parameter int GATE_CYCLES = 5000000,
    parameter int CNT_W       = 23,
    parameter int WORD_W      = 32
) (
    input logic                  clk,
    input logic                  rst_n,
    input logic                  lock_in,
    input logic                  word_stb_o,
    input logic [WORD_W-1:0]     word_o,
    input logic                  track_o,
    input ftrk_pkg::trk_state_t  state_q,
    input logic [CNT_W-1:0]      win_count
);

    import ftrk_pkg::*;

    localparam int AW = $clog2(GATE_CYCLES + 8) + 1;
    logic [AW-1:0] age_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                             age_q <= '0;
        else if (age_q != AW'(GATE_CYCLES + 8)) age_q <= age_q + AW'(1);
    end

    p_no_overflow_r2: assert property (@(posedge clk) disable iff (!rst_n)
        win_count <= CNT_W'(GATE_CYCLES));

    p_stb_pulse_r4: assert property (@(posedge clk) disable iff (!rst_n)
        word_stb_o |=> !word_stb_o);

    p_seq_a_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_SCALE_A) |=> (state_q == ST_SCALE_B));

    p_seq_b_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_SCALE_B) |=> (state_q == ST_PUBLISH));

    p_seq_p_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_PUBLISH) |=> (state_q == ST_GATE));

    p_word_frozen_r5: assert property (@(posedge clk) disable iff (!rst_n)
        !word_stb_o |-> $stable(word_o));

    p_hold_quiet_r5: assert property (@(posedge clk) disable iff (!rst_n)
        word_stb_o |-> $past(track_o));

    p_lock_quiet_r6: assert property (@(posedge clk) disable iff (!rst_n)
        word_stb_o |-> !$past(lock_in));

    p_first_window_r8: assert property (@(posedge clk) disable iff (!rst_n)
        word_stb_o |-> (age_q >= AW'(GATE_CYCLES + 4)));

endmodule

bind gated_freq_tracker ftrk_checker #(
    .GATE_CYCLES (GATE_CYCLES),
    .CNT_W       (CNT_W),
    .WORD_W      (WORD_W)
) u_ftrk_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .lock_in    (lock_in),
    .word_stb_o (word_stb_o),
    .word_o     (word_o),
    .track_o    (track_o),
    .state_q    (state_q),
    .win_count  (win_count)
);

// File: tb/gated_freq_tracker_bench.sv
`timescale 1ns/1ps
module gated_freq_tracker_bench;

    localparam int              G     = 240;
    localparam int              HOLD  = 8;
    localparam longint unsigned SCALE = 64'd360287970;
    localparam int              SHR   = 50;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        ref_in = 1'b0;
    logic        sense_in = 1'b1;
    logic        lock_in = 1'b0;
    logic [31:0] corr_in = 32'h4000_0000;
    logic [31:0] word_o;
    logic        word_stb_o;
    logic        track_o;

    int     checks = 0;
    int     errors = 0;
    longint cyc = 0;
    longint total = 0;
    int     per = 0;
    int     ph = 0;

    gated_freq_tracker #(
        .GATE_CYCLES (G),
        .HOLD_CYCLES (HOLD)
    ) u_gated_freq_tracker (
        .clk        (clk),
        .rst_n      (rst_n),
        .ref_in     (ref_in),
        .sense_in   (sense_in),
        .lock_in    (lock_in),
        .corr_in    (corr_in),
        .word_o     (word_o),
        .word_stb_o (word_stb_o),
        .track_o    (track_o)
    );

    always #10 clk = ~clk;

    always @(posedge clk) begin
        total <= total + 1;
        if (!rst_n) cyc <= 0;
        else        cyc <= cyc + 1;
    end

    // Reference oscillator: one rising edge every per cycles
    always @(negedge clk) begin
        if (per == 0) begin
            ref_in <= 1'b0;
            ph     <= 0;
        end else begin
            int nx;
            nx = (ph + 1 >= per) ? 0 : ph + 1;
            ph     <= nx;
            ref_in <= (nx < per / 2);
        end
    end

    always @(posedge clk) begin
        if (total > 150000) begin
            errors = errors + 1;
            $display("FAIL watchdog: actual %0d cycles expected completion", total);
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    task automatic check(input bit ok, input string req, input longint act, input longint exp);
        checks = checks + 1;
        if (!ok) begin
            errors = errors + 1;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    function automatic logic [31:0] exp_word(input int unsigned cnt, input logic [31:0] c);
        logic [127:0] p;
        p = 128'(cnt) * 128'(SCALE) * 128'(c);
        return p[SHR +: 32];
    endfunction

    task automatic wait_stb(output longint at);
        at = -1;
        for (int n = 0; n < 2000; n++) begin
            @(negedge clk);
            if (word_stb_o) begin
                at = cyc;
                break;
            end
        end
        if (at < 0) check(1'b0, "R4 strobe timeout", 0, 1);
    endtask

    task automatic count_stb(input int ncyc, output int got);
        got = 0;
        for (int n = 0; n < ncyc; n++) begin
            @(negedge clk);
            if (word_stb_o) got++;
        end
    endtask

    initial begin
        longint      t1, t2;
        int          got;
        logic [31:0] w0;
        logic [31:0] corrs [4];
        int          pers [18];
        bit          glitch_ok;

        corrs = '{32'h4000_0000, 32'h5000_0000, 32'h3000_0000, 32'hFFFF_FFFF};
        pers  = '{3, 4, 5, 6, 8, 10, 12, 15, 16, 20, 24, 30, 40, 48, 60, 80, 120, 240};

        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        // R1: reset state
        check(word_o == 32'd0, "R1 word after reset", word_o, 0);
        check(word_stb_o == 1'b0, "R1 strobe after reset", word_stb_o, 0);
        check(track_o == 1'b0, "R1 mode after reset", track_o, 0);

        // R8: first strobe timing, R3: zero count gives zero word
        wait_stb(t1);
        check(t1 == G + 4, "R8 first strobe edge", t1, G + 4);
        check(word_o == 32'd0, "R3 zero count word", word_o, 0);
        check(track_o == 1'b1, "R7 track accepted", track_o, 1);

        // R2/R3/R4: sweep of periods and correction factors
        foreach (corrs[ci]) begin
            foreach (pers[pi]) begin
                per     = pers[pi];
                corr_in = corrs[ci];
                wait_stb(t1);
                wait_stb(t2);
                check(word_o == exp_word(G / per, corrs[ci]), "R2 R3 scaled count",
                      word_o, exp_word(G / per, corrs[ci]));
                check(t2 - t1 == G, "R4 strobe spacing", t2 - t1, G);
            end
        end

        // R5: hold freezes the word
        corr_in  = 32'h4000_0000;
        per      = 6;
        wait_stb(t1);
        wait_stb(t1);
        w0       = word_o;
        sense_in = 1'b0;
        per      = 5;
        count_stb(3 * G, got);
        check(got == 0, "R5 no strobe in hold", got, 0);
        check(word_o == w0, "R5 word frozen in hold", word_o, w0);
        check(track_o == 1'b0, "R5 hold accepted", track_o, 0);

        // R9: resume after hold
        sense_in = 1'b1;
        wait_stb(t1);
        check(word_o == exp_word(G / 5, 32'h4000_0000), "R9 resume after hold",
              word_o, exp_word(G / 5, 32'h4000_0000));

        // R6: lock freezes the word while tracking
        wait_stb(t1);
        w0      = word_o;
        lock_in = 1'b1;
        per     = 8;
        count_stb(3 * G, got);
        check(got == 0, "R6 no strobe under lock", got, 0);
        check(word_o == w0, "R6 word frozen under lock", word_o, w0);
        check(track_o == 1'b1, "R6 mode still track", track_o, 1);
        lock_in = 1'b0;
        wait_stb(t1);
        check(word_o == exp_word(G / 8, 32'h4000_0000), "R9 resume after lock",
              word_o, exp_word(G / 8, 32'h4000_0000));

        // R7: glitch shorter than the filter window is ignored
        glitch_ok = 1'b1;
        sense_in  = 1'b0;
        repeat (HOLD - 1) begin
            @(negedge clk);
            if (!track_o) glitch_ok = 1'b0;
        end
        sense_in = 1'b1;
        repeat (12) begin
            @(negedge clk);
            if (!track_o) glitch_ok = 1'b0;
        end
        check(glitch_ok, "R7 short glitch ignored", glitch_ok, 1);

        // R7: exact acceptance latency
        sense_in = 1'b0;
        repeat (HOLD + 1) @(negedge clk);
        check(track_o == 1'b1, "R7 before acceptance edge", track_o, 1);
        @(negedge clk);
        check(track_o == 1'b0, "R7 at acceptance edge", track_o, 0);
        sense_in = 1'b1;
        repeat (HOLD + 1) @(negedge clk);
        check(track_o == 1'b0, "R7 before return edge", track_o, 0);
        @(negedge clk);
        check(track_o == 1'b1, "R7 at return edge", track_o, 1);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule